// File: doc/BRIEF.md
# Serial Receiver with Mute and Wake-Up Control

This block is the receive side of an asynchronous serial port. It frames bytes as one start bit, eight data bits sent least-significant bit first, and one stop bit. Each bit lasts `OVS` clock cycles. The block takes one sample at the middle of each bit. A finished byte goes into a data register and raises a full flag. A byte that finishes while the register is still unread raises an overrun flag instead. A line that stays high for `IDLE_BITS` bit times after a received byte raises an idle flag. Two enables combine these flags into a single interrupt request.

Software can put the receiver into mute mode. While it is muted, traffic that is not addressed to this node leaves the flags and the interrupt request unchanged. The hardware leaves mute mode on its own when it sees a wake-up event. A configuration input picks the kind of event: either an idle line or an address byte whose top bit is 1. The mute write is guarded in two cases. When address wake-up is selected, a write is refused while received data is still unread. When idle wake-up is selected, a request to enter mute mode is refused until a byte has been received since the receiver was enabled.

Top module: `sci_rx_wake_ctl`

## Requirements
- R1: A frame consists of a low start bit, then 8 data bits with the least-significant bit first, then a stop bit, each bit lasting OVS clocks. When the sampled stop bit is 1 and the receiver is not muted, the byte is loaded into `rx_data_o` and `full_o` rises.
- R2: While `rx_en_i` is 0, the receiver ignores activity on `rx_i`. No flag changes.
- R3: If a byte completes while `full_o` is 1, `ovr_o` rises and `rx_data_o` keeps its previous value.
- R4: A one-cycle pulse on `rd_i` clears `full_o`, `ovr_o` and `idle_o`.
- R5: After a received byte, if the line stays high for IDLE_BITS bit times while the receiver is not muted, `idle_o` rises.
- R6: When `full_ie_i` is 1, `irq_o` is 1 whenever `full_o` or `ovr_o` is 1.
- R7: When `idle_ie_i` is 1, `irq_o` is 1 whenever `idle_o` is 1.
- R8: While `mute_o` is 1, bytes that do not wake the receiver leave `full_o`, `ovr_o` and `idle_o` unchanged.
- R9: With `wake_sel_i` = 0 (idle wake-up), an idle line clears `mute_o`, and that idle event does not set `idle_o`.
- R10: With `wake_sel_i` = 1 (address wake-up), a byte whose bit 7 is 1 clears `mute_o` and is itself delivered with `full_o` set. Bytes whose bit 7 is 0 are dropped while muted.
- R11: With `wake_sel_i` = 1, a write on `mute_wr_i` is ignored while `full_o` is 1.
- R12: With `wake_sel_i` = 0, a request to set mute is ignored until a byte has been received since `rx_en_i` last rose.
- R13: A frame whose sampled stop bit is 0 is discarded. The receiver then waits for the line to return high before it looks for the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| wake_sel_i | input | 1 | Wake-up source: 0 = idle line, 1 = address byte |
| mute_wr_i | input | 1 | One-cycle write strobe for the mute bit |
| mute_val_i | input | 1 | Value written to the mute bit |
| rd_i | input | 1 | One-cycle data-register read strobe |
| full_ie_i | input | 1 | Interrupt enable for full and overrun |
| idle_ie_i | input | 1 | Interrupt enable for idle |
| rx_data_o | output | 8 | Received data register |
| full_o | output | 1 | Receive data register full |
| ovr_o | output | 1 | Overrun |
| idle_o | output | 1 | Idle line detected |
| mute_o | output | 1 | Mute mode active |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong mute state shows up at the ports within one frame. A receiver stuck in mute mode stops raising `full_o` for ordinary bytes. A receiver that missed a wake-up keeps dropping the byte that should have been delivered. A wrong guard on the mute write shows up on `mute_o` on the cycle after the strobe. A corrupted bit counter or sample point gives a wrong value in `rx_data_o` as soon as one byte has completed. A broken idle counter shows up after IDLE_BITS bit times, as either a missing idle flag or a missed idle wake-up.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_HOLD
  } rx_state_e;

  // cycle index of the middle of a bit, counted from the falling edge
  function automatic int mid_tick(input int ovs);
    return ovs / 2 - 1;
  endfunction

  // clocks of continuous high line that count as an idle frame
  function automatic int idle_ticks(input int bits, input int ovs);
    return bits * ovs;
  endfunction
endpackage

// File: rtl/sci_rx_frame.sv
module sci_rx_frame
  import sci_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_in,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              line_idle
);
  localparam int HALF  = mid_tick(OVS);
  localparam int ILIM  = idle_ticks(IDLE_BITS, OVS);
  localparam int CW    = $clog2(OVS + 1);
  localparam int BW    = $clog2(DATA_W + 1);
  localparam int IW    = $clog2(ILIM + 1);

  logic [1:0]        sync_q;
  logic              rxs;
  rx_state_e         state;
  logic [CW-1:0]     tick;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     idle_cnt;
  logic              armed;

  assign rxs = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tick      <= '0;
      bitn      <= '0;
      shreg     <= '0;
      byte_val  <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!rx_en) begin
        state <= ST_IDLE;
        tick  <= '0;
      end else begin
        case (state)
          ST_IDLE: if (!rxs) begin
            state <= ST_START;
            tick  <= '0;
          end
          ST_START: begin
            if (tick == CW'(HALF)) begin
              tick <= '0;
              bitn <= '0;
              state <= rxs ? ST_IDLE : ST_DATA;
            end else tick <= tick + 1'b1;
          end
          ST_DATA: begin
            if (tick == CW'(OVS - 1)) begin
              tick  <= '0;
              shreg <= {rxs, shreg[DATA_W-1:1]};
              if (bitn == BW'(DATA_W - 1)) state <= ST_STOP;
              else bitn <= bitn + 1'b1;
            end else tick <= tick + 1'b1;
          end
          ST_STOP: begin
            if (tick == CW'(OVS - 1)) begin
              tick <= '0;
              if (rxs) begin
                byte_done <= 1'b1;
                byte_val  <= shreg;
                state     <= ST_IDLE;
              end else state <= ST_HOLD;
            end else tick <= tick + 1'b1;
          end
          ST_HOLD: if (rxs) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // idle detector: armed by a received byte, fires once per high stretch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      armed     <= 1'b0;
      line_idle <= 1'b0;
    end else begin
      line_idle <= 1'b0;
      if (!rx_en) begin
        idle_cnt <= '0;
        armed    <= 1'b0;
      end else if (byte_done) begin
        armed    <= 1'b1;
        idle_cnt <= '0;
      end else if (state != ST_IDLE || !rxs || !armed) begin
        idle_cnt <= '0;
      end else if (idle_cnt == IW'(ILIM - 1)) begin
        line_idle <= 1'b1;
        armed     <= 1'b0;
        idle_cnt  <= '0;
      end else idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R2
  no_byte_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !byte_done);
  // R13
  hold_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !byte_done);
endmodule

// File: rtl/sci_rx_mute.sv
module sci_rx_mute (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic wake_sel,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic data_full,
  input  logic byte_done,
  input  logic byte_msb,
  input  logic line_idle,
  output logic mute,
  output logic addr_wake
);
  logic got_byte;
  logic idle_wake;
  logic sw_ok;

  assign idle_wake = mute && !wake_sel && line_idle;
  assign addr_wake = mute && wake_sel && byte_done && byte_msb;
  assign sw_ok     = sw_wr && !(wake_sel && data_full)
                     && !(sw_val && !wake_sel && !got_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) got_byte <= 1'b0;
    else if (!rx_en) got_byte <= 1'b0;
    else if (byte_done) got_byte <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute <= 1'b0;
    else if (idle_wake || addr_wake) mute <= 1'b0;
    else if (sw_ok) mute <= sw_val;
  end

  // R11
  addr_mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && wake_sel && data_full && !addr_wake) |=> $stable(mute));
  // R12
  idle_mode_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_val && !wake_sel && !got_byte && !mute) |=> !mute);
  // R10
  addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && wake_sel && byte_done && byte_msb) |=> !mute);
  // R9
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && !wake_sel && line_idle) |=> !mute);
endmodule

// File: rtl/sci_rx_flags.sv
module sci_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              deliver,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              idle_evt,
  input  logic              full_ie,
  input  logic              idle_ie,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              ovr,
  output logic              idle,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
      idle <= 1'b0;
    end else begin
      if (rd) begin
        full <= 1'b0;
        ovr  <= 1'b0;
        idle <= 1'b0;
      end
      if (deliver) begin
        if (full && !rd) ovr <= 1'b1;
        else begin
          data <= byte_val;
          full <= 1'b1;
        end
      end
      if (idle_evt) idle <= 1'b1;
    end
  end

  assign irq = (full_ie && (full || ovr)) || (idle_ie && idle);

  // R3
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && full && !rd) |=> (ovr && $stable(data)));
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !deliver && !idle_evt) |=> (!full && !ovr && !idle));
endmodule

// File: rtl/sci_rx_wake_ctl.sv
module sci_rx_wake_ctl
  import sci_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              wake_sel_i,
  input  logic              mute_wr_i,
  input  logic              mute_val_i,
  input  logic              rd_i,
  input  logic              full_ie_i,
  input  logic              idle_ie_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              idle_o,
  output logic              mute_o,
  output logic              irq_o
);
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;
  logic              line_idle;
  logic              addr_wake;
  logic              deliver;
  logic              idle_evt;

  sci_rx_frame #(.OVS(OVS), .DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en_i), .rx_in(rx_i),
    .byte_done(byte_done), .byte_val(byte_val), .line_idle(line_idle)
  );

  sci_rx_mute u_mute (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en_i), .wake_sel(wake_sel_i),
    .sw_wr(mute_wr_i), .sw_val(mute_val_i), .data_full(full_o),
    .byte_done(byte_done), .byte_msb(byte_val[DATA_W-1]),
    .line_idle(line_idle), .mute(mute_o), .addr_wake(addr_wake)
  );

  assign deliver  = byte_done && (!mute_o || addr_wake);
  assign idle_evt = line_idle && !mute_o;

  sci_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .rd(rd_i), .deliver(deliver),
    .byte_val(byte_val), .idle_evt(idle_evt), .full_ie(full_ie_i),
    .idle_ie(idle_ie_i), .data(rx_data_o), .full(full_o), .ovr(ovr_o),
    .idle(idle_o), .irq(irq_o)
  );

  // R8
  muted_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && mute_o && !addr_wake && !rd_i) |=> ($stable(full_o) && $stable(ovr_o)));
  // R6
  full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ie_i && (full_o || ovr_o)) |-> irq_o);
  // R7
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ie_i && idle_o) |-> irq_o);
endmodule

// File: tb/test_sci_rx_wake_ctl.sv
module test_sci_rx_wake_ctl;
  localparam int OVS = 16;
  localparam int NV  = 6;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h3C, 8'h81};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, rx_en = 1'b0, wake_sel = 1'b0, mute_wr = 1'b0, mute_val = 1'b0;
  logic rd = 1'b0, full_ie = 1'b0, idle_ie = 1'b0;
  logic [7:0] data;
  logic full, ovr, idle, mute, irq;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sci_rx_wake_ctl #(.OVS(OVS)) i_sci_rx_wake_ctl (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .rx_en_i(rx_en), .wake_sel_i(wake_sel),
    .mute_wr_i(mute_wr), .mute_val_i(mute_val), .rd_i(rd), .full_ie_i(full_ie),
    .idle_ie_i(idle_ie), .rx_data_o(data), .full_o(full), .ovr_o(ovr),
    .idle_o(idle), .mute_o(mute), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bits(input int n);
    repeat (n * OVS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    rx = 1'b0; bits(1);
    for (int i = 0; i < 8; i++) begin rx = b[i]; bits(1); end
    rx = stop; bits(1);
    rx = 1'b1; bits(2);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic write_mute(input logic v);
    mute_val = v; mute_wr = 1'b1; @(negedge clk); mute_wr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {full, ovr, idle, mute, irq}, 5'b0);
    rx_en = 1'b1; bits(1);
    // R12: no byte yet since enable
    write_mute(1'b1);
    check("R12 refuse before byte", mute, 1'b0);
    // R1: vector table
    for (int k = 0; k < NV; k++) begin
      send(VEC[k], 1'b1);
      check("R1 data", data, VEC[k]);
      check("R1 full", full, 1'b1);
      pulse_rd();
      check("R4 full cleared", full, 1'b0);
    end
    // R3 overrun, R6 irq
    send(8'h12, 1'b1);
    send(8'h34, 1'b1);
    check("R3 ovr", ovr, 1'b1);
    check("R3 data kept", data, 8'h12);
    check("R6 irq off", irq, 1'b0);
    full_ie = 1'b1; @(negedge clk);
    check("R6 irq", irq, 1'b1);
    pulse_rd();
    check("R4 clear", {full, ovr}, 2'b00);
    check("R6 irq dropped", irq, 1'b0);
    full_ie = 1'b0;
    // R5 idle, R7 irq
    bits(12);
    check("R5 idle", idle, 1'b1);
    idle_ie = 1'b1; @(negedge clk);
    check("R7 irq", irq, 1'b1);
    pulse_rd();
    check("R4 idle cleared", idle, 1'b0);
    idle_ie = 1'b0;
    // R8 / R9 idle wake-up
    write_mute(1'b1);
    check("R12 accept after byte", mute, 1'b1);
    send(8'h42, 1'b1);
    check("R8 muted full", full, 1'b0);
    check("R8 still muted", mute, 1'b1);
    bits(12);
    check("R9 woke", mute, 1'b0);
    check("R9 no idle flag", idle, 1'b0);
    // R10 address wake-up
    wake_sel = 1'b1;
    write_mute(1'b1);
    check("R10 mute set", mute, 1'b1);
    send(8'h35, 1'b1);
    check("R10 non-addr dropped", full, 1'b0);
    check("R10 still muted", mute, 1'b1);
    send(8'hA5, 1'b1);
    check("R10 woke", mute, 1'b0);
    check("R10 full", full, 1'b1);
    check("R10 data", data, 8'hA5);
    // R11 write locked while full
    write_mute(1'b1);
    check("R11 locked", mute, 1'b0);
    pulse_rd();
    write_mute(1'b1);
    check("R11 unlocked", mute, 1'b1);
    send(8'h80, 1'b1);
    check("R10 wake 80", mute, 1'b0);
    pulse_rd();
    bits(12);
    pulse_rd();
    // R2 disabled receiver
    rx_en = 1'b0;
    send(8'h77, 1'b1);
    check("R2 ignored", {full, ovr, idle}, 3'b000);
    rx_en = 1'b1; wake_sel = 1'b0; bits(1);
    write_mute(1'b1);
    check("R12 refuse after re-enable", mute, 1'b0);
    // R13 framing error
    send(8'h5A, 1'b0);
    check("R13 discarded", full, 1'b0);
    send(8'hC3, 1'b1);
    check("R13 next byte", data, 8'hC3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule